// File: doc/BRIEF.md
# Per-Lane Strobed DDR Read Capture

This block takes double-data-rate read data that arrives on a set of independent byte lanes and turns it into full-width words in the controller clock domain. Each lane is 8 data bits plus one mask bit, and each lane has its own source-synchronous strobe. That strobe is the only clock used to sample the lane. The first byte of a pair is taken on the strobe's rising edge and is called the even byte. The second is taken on the falling edge and is called the odd byte. Once the odd byte is in, the lane writes the complete pair into its own slice of a shared FIFO.

The FIFO has one read pointer for all lanes, owned by the controller clock. Each lane has its own write pointer. Pointers cross between domains as Gray code through two-flop synchronisers. A word counts as available only when every lane has written its pair for that word. A read request on an available word pops it into an output register, and the valid flag is high for one controller cycle.

The controller side is a two-state machine. ST_IDLE means no word is being delivered. ST_SHOW means the output register holds a word popped at the previous edge. A pop moves the machine from either state to ST_SHOW. Any cycle without a pop moves it to ST_IDLE. If a lane writes while its FIFO slice is full, the pair is discarded and a sticky overflow flag is raised, which only reset clears. A read request while no complete word exists is ignored.

Top module: `ddr_rd_capture`

## Requirements
- R1: For lane l, the even byte is sampled on the rising edge of lane_dqs[l] and the odd byte on the following falling edge. A popped word carries the even byte in rd_data[16l+7:16l] and the odd byte in rd_data[16l+15:16l+8].
- R2: Lane l's mask bit is sampled on the same two edges as its data. The even mask appears in rd_mask[2l] and the odd mask in rd_mask[2l+1].
- R3: Each lane is sampled only by its own strobe. When lanes deliver their pairs one after another at different times, the popped word is the same as when all lanes strobe together.
- R4: fifo_empty stays high until every lane has written its pair for the oldest word. It goes low no later than the third controller rising edge after the last lane's falling strobe edge.
- R5: Each read request made while fifo_empty is low gives exactly one cycle of rd_valid, on the cycle after the request. Requests held high on consecutive cycles give one word per cycle. rd_data and rd_mask hold their value in any cycle that follows a cycle without a pop.
- R6: Words come out in the order they were written. With nothing read, the FIFO stores 2^AW words.
- R7: A read request while fifo_empty is high has no effect. rd_valid stays low, and the next word written is the next word read.
- R8: A lane write while that lane's slice holds 2^AW unread pairs discards the pair and sets overflow. overflow then stays high until reset, and the words already stored are read out unchanged.
- R9: While ctl_rst_n is low, rd_valid and overflow are low and fifo_empty is high. Reset empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Controller clock |
| ctl_rst_n | input | 1 | Asynchronous active-low reset for all domains |
| lane_dqs | input | LANES | Per-lane read strobes |
| lane_dq | input | 8*LANES | Per-lane read data, lane l in bits [8l+7:8l] |
| lane_dm | input | LANES | Per-lane mask bit |
| rd_en | input | 1 | Read request, controller domain |
| rd_data | output | 16*LANES | Popped word: even/odd byte pair per lane |
| rd_mask | output | 2*LANES | Popped mask pair per lane |
| rd_valid | output | 1 | High for one cycle per popped word |
| fifo_empty | output | 1 | No complete word is available |
| overflow | output | 1 | Sticky: a lane write was discarded |

## Verification
The bench builds the block with LANES=3 and AW=2. An odd lane count checks that lane slicing does not assume a power of two. A four-word depth lets the overflow case, and reading out the full contents in order, happen within a few short bursts. Strobes are driven both together and lane by lane, with gaps of several controller cycles between lanes, so the all-lanes-present rule for fifo_empty is seen with partially written words.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              dm_odd;
        logic              dm_even;
        logic [BYTE_W-1:0] dq_odd;
        logic [BYTE_W-1:0] dq_even;
    } lane_pair_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } out_state_e;

endpackage

// File: rtl/ddr_gray_sync.sv
// Two-flop synchroniser for a Gray-coded (or single-bit) value.
module ddr_gray_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            d_out  <= '0;
        end else begin
            meta_q <= d_in;
            d_out  <= meta_q;
        end
    end
endmodule

// File: rtl/ddr_gray_dec.sv
// Gray to binary: each binary bit is the parity of the Gray bits at and above it.
module ddr_gray_dec #(
    parameter int W = 4
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^gray[W-1:i];
    end
endmodule

// File: rtl/ddr_lane_capture.sv
// One byte lane: samples on its own strobe and writes the even/odd pair into its FIFO slice.
module ddr_lane_capture
    import ddr_cap_pkg::*;
#(
    parameter int AW = 3,
    localparam int PW = AW + 1,
    localparam int DEPTH = 1 << AW
) (
    input  logic              rst_n,
    input  logic              dqs,
    input  logic [BYTE_W-1:0] dq,
    input  logic              dm,
    input  logic [PW-1:0]     rd_ptr_gray,
    input  logic [AW-1:0]     rd_addr,
    output logic [PW-1:0]     wr_ptr_gray,
    output lane_pair_t        rd_pair,
    output logic              ovf
);
    logic [BYTE_W-1:0] even_dq_q;
    logic              even_dm_q;
    logic [PW-1:0]     wptr_q;
    logic [PW-1:0]     wptr_nx;
    logic [PW-1:0]     rp_gray_s;
    logic [PW-1:0]     rp_bin_s;
    logic [PW-1:0]     fill;
    logic              full;
    lane_pair_t        mem [DEPTH];

    // Even half of the pair: rising strobe edge.
    always_ff @(posedge dqs or negedge rst_n) begin
        if (!rst_n) begin
            even_dq_q <= '0;
            even_dm_q <= 1'b0;
        end else begin
            even_dq_q <= dq;
            even_dm_q <= dm;
        end
    end

    // Read pointer brought into the strobe domain.
    ddr_gray_sync #(.W(PW)) u_rsync (
        .clk   (dqs),
        .rst_n (rst_n),
        .d_in  (rd_ptr_gray),
        .d_out (rp_gray_s)
    );

    ddr_gray_dec #(.W(PW)) u_rdec (
        .gray (rp_gray_s),
        .bin  (rp_bin_s)
    );

    assign fill    = wptr_q - rp_bin_s;
    assign full    = fill[AW];
    assign wptr_nx = wptr_q + PW'(1);

    // Odd half on the falling edge completes the pair and commits it.
    always_ff @(negedge dqs or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q      <= '0;
            wr_ptr_gray <= '0;
            ovf         <= 1'b0;
        end else if (full) begin
            ovf         <= 1'b1;
        end else begin
            wptr_q      <= wptr_nx;
            wr_ptr_gray <= wptr_nx ^ (wptr_nx >> 1);
        end
    end

    always_ff @(negedge dqs) begin
        if (!full) begin
            mem[wptr_q[AW-1:0]] <= '{dm_odd:  dm,
                                     dm_even: even_dm_q,
                                     dq_odd:  dq,
                                     dq_even: even_dq_q};
        end
    end

    assign rd_pair = mem[rd_addr];
endmodule

// File: rtl/ddr_rd_capture.sv
// Multi-lane DDR read capture with a shared controller-side FIFO read port.
module ddr_rd_capture
    import ddr_cap_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 3,
    localparam int PW     = AW + 1,
    localparam int DQ_W   = BYTE_W * LANES,
    localparam int WORD_W = 2 * BYTE_W * LANES,
    localparam int MASK_W = 2 * LANES
) (
    input  logic              ctl_clk,
    input  logic              ctl_rst_n,
    input  logic [LANES-1:0]  lane_dqs,
    input  logic [DQ_W-1:0]   lane_dq,
    input  logic [LANES-1:0]  lane_dm,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic [MASK_W-1:0] rd_mask,
    output logic              rd_valid,
    output logic              fifo_empty,
    output logic              overflow
);
    logic [PW-1:0]    rptr_q;
    logic [PW-1:0]    rptr_nx;
    logic [PW-1:0]    rgray_q;
    logic [LANES-1:0] lane_has;
    logic [LANES-1:0] ovf_raw;
    logic [LANES-1:0] ovf_s;
    lane_pair_t       pairs [LANES];
    logic             avail;
    logic             pop;
    out_state_e       state_q;
    out_state_e       state_nx;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [PW-1:0] wgray;
        logic [PW-1:0] wgray_s;
        logic [PW-1:0] wbin_s;

        ddr_lane_capture #(.AW(AW)) u_lane (
            .rst_n       (ctl_rst_n),
            .dqs         (lane_dqs[l]),
            .dq          (lane_dq[BYTE_W*l +: BYTE_W]),
            .dm          (lane_dm[l]),
            .rd_ptr_gray (rgray_q),
            .rd_addr     (rptr_q[AW-1:0]),
            .wr_ptr_gray (wgray),
            .rd_pair     (pairs[l]),
            .ovf         (ovf_raw[l])
        );

        ddr_gray_sync #(.W(PW)) u_wsync (
            .clk   (ctl_clk),
            .rst_n (ctl_rst_n),
            .d_in  (wgray),
            .d_out (wgray_s)
        );

        ddr_gray_dec #(.W(PW)) u_wdec (
            .gray (wgray_s),
            .bin  (wbin_s)
        );

        ddr_gray_sync #(.W(1)) u_osync (
            .clk   (ctl_clk),
            .rst_n (ctl_rst_n),
            .d_in  (ovf_raw[l]),
            .d_out (ovf_s[l])
        );

        assign lane_has[l] = (wbin_s != rptr_q);
    end

    assign avail      = &lane_has;
    assign fifo_empty = ~avail;
    assign overflow   = |ovf_s;
    assign pop        = rd_en & avail;
    assign rptr_nx    = rptr_q + PW'(1);

    // Shared read pointer, kept in binary and Gray form.
    always_ff @(posedge ctl_clk or negedge ctl_rst_n) begin
        if (!ctl_rst_n) begin
            rptr_q  <= '0;
            rgray_q <= '0;
        end else if (pop) begin
            rptr_q  <= rptr_nx;
            rgray_q <= rptr_nx ^ (rptr_nx >> 1);
        end
    end

    // Output word register.
    always_ff @(posedge ctl_clk or negedge ctl_rst_n) begin
        if (!ctl_rst_n) begin
            rd_data <= '0;
            rd_mask <= '0;
        end else if (pop) begin
            for (int l = 0; l < LANES; l++) begin
                rd_data[2*BYTE_W*l +: 2*BYTE_W] <= {pairs[l].dq_odd, pairs[l].dq_even};
                rd_mask[2*l +: 2]               <= {pairs[l].dm_odd, pairs[l].dm_even};
            end
        end
    end

    // Delivery state machine.
    always_ff @(posedge ctl_clk or negedge ctl_rst_n) begin
        if (!ctl_rst_n) state_q <= ST_IDLE;
        else            state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: state_nx = pop ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_nx = pop ? ST_SHOW : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_valid = (state_q == ST_SHOW);
    end
endmodule

// File: rtl/ddr_rd_capture_chk.sv
module ddr_rd_capture_chk #(
    parameter int WORD_W = 64,
    parameter int MASK_W = 8
) (
    input logic              ctl_clk,
    input logic              ctl_rst_n,
    input logic              rd_en,
    input logic [WORD_W-1:0] rd_data,
    input logic [MASK_W-1:0] rd_mask,
    input logic              rd_valid,
    input logic              fifo_empty,
    input logic              overflow
);
    p_valid_after_pop_r5: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
        rd_valid |-> $past(rd_en && !fifo_empty));

    p_pop_gives_valid_r5: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
        (rd_en && !fifo_empty) |=> rd_valid);

    p_word_holds_r5: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
        !(rd_en && !fifo_empty) |=> ($stable(rd_data) && $stable(rd_mask)));

    p_empty_read_ignored_r7: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
        (rd_en && fifo_empty) |=> !rd_valid);

    p_overflow_sticky_r8: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
        overflow |=> overflow);

    p_reset_state_r9: assert property (@(posedge ctl_clk)
        (!ctl_rst_n && $past(!ctl_rst_n)) |-> (!rd_valid && fifo_empty && !overflow));
endmodule

bind ddr_rd_capture ddr_rd_capture_chk #(.WORD_W(WORD_W), .MASK_W(MASK_W)) u_chk (
    .ctl_clk    (ctl_clk),
    .ctl_rst_n  (ctl_rst_n),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rd_mask    (rd_mask),
    .rd_valid   (rd_valid),
    .fifo_empty (fifo_empty),
    .overflow   (overflow)
);

// File: tb/ddr_rd_capture_tb_top.sv
`timescale 1ns/1ps
module ddr_rd_capture_tb_top;
    localparam int L     = 3;
    localparam int AW    = 2;
    localparam int DEPTH = 1 << AW;
    localparam int WW    = 16 * L;
    localparam int MW    = 2 * L;

    logic          ctl_clk = 1'b0;
    logic          ctl_rst_n = 1'b1;
    logic [L-1:0]  lane_dqs = '0;
    logic [8*L-1:0] lane_dq = '0;
    logic [L-1:0]  lane_dm = '0;
    logic          rd_en = 1'b0;
    logic [WW-1:0] rd_data;
    logic [MW-1:0] rd_mask;
    logic          rd_valid;
    logic          fifo_empty;
    logic          overflow;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #5 ctl_clk = ~ctl_clk;

    ddr_rd_capture #(.LANES(L), .AW(AW)) dut_i (
        .ctl_clk    (ctl_clk),
        .ctl_rst_n  (ctl_rst_n),
        .lane_dqs   (lane_dqs),
        .lane_dq    (lane_dq),
        .lane_dm    (lane_dm),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .rd_mask    (rd_mask),
        .rd_valid   (rd_valid),
        .fifo_empty (fifo_empty),
        .overflow   (overflow)
    );

    function automatic logic [WW-1:0] mk_data(int n);
        logic [WW-1:0] d;
        for (int i = 0; i < 2 * L; i++) d[8*i +: 8] = 8'(n * 37 + i * 11 + 3);
        return d;
    endfunction

    function automatic logic [MW-1:0] mk_mask(int n);
        return MW'(n * 5 + 9);
    endfunction

    task automatic check(bit ok, string req, logic [WW-1:0] act, logic [WW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        ctl_rst_n = 1'b0;
        repeat (3) @(negedge ctl_clk);
        ctl_rst_n = 1'b1;
        @(negedge ctl_clk);
    endtask

    task automatic drive_lane(int l, logic [WW-1:0] d, logic [MW-1:0] m);
        lane_dq[8*l +: 8] = d[16*l +: 8];
        lane_dm[l]        = m[2*l];
        #2 lane_dqs[l]    = 1'b1;
        #1;
        lane_dq[8*l +: 8] = d[16*l+8 +: 8];
        lane_dm[l]        = m[2*l+1];
        #2 lane_dqs[l]    = 1'b0;
        #1;
    endtask

    task automatic push_all(logic [WW-1:0] d, logic [MW-1:0] m);
        for (int l = 0; l < L; l++) begin
            lane_dq[8*l +: 8] = d[16*l +: 8];
            lane_dm[l]        = m[2*l];
        end
        #2 lane_dqs = '1;
        #1;
        for (int l = 0; l < L; l++) begin
            lane_dq[8*l +: 8] = d[16*l+8 +: 8];
            lane_dm[l]        = m[2*l+1];
        end
        #2 lane_dqs = '0;
        #1;
    endtask

    task automatic settle();
        repeat (4) @(negedge ctl_clk);
    endtask

    task automatic pop_check(int n, string req);
        @(negedge ctl_clk);
        rd_en = 1'b1;
        @(negedge ctl_clk);
        rd_en = 1'b0;
        check(rd_valid === 1'b1, req, WW'(rd_valid), WW'(1));
        check(rd_data === mk_data(n), req, rd_data, mk_data(n));
        check(rd_mask === mk_mask(n), req, WW'(rd_mask), WW'(mk_mask(n)));
        @(negedge ctl_clk);
        check(rd_valid === 1'b0, "R5 single-cycle valid", WW'(rd_valid), WW'(0));
    endtask

    task automatic t_reset();
        do_reset();
        check(fifo_empty === 1'b1, "R9 empty after reset", WW'(fifo_empty), WW'(1));
        check(rd_valid === 1'b0, "R9 valid after reset", WW'(rd_valid), WW'(0));
        check(overflow === 1'b0, "R9 overflow after reset", WW'(overflow), WW'(0));
    endtask

    task automatic t_basic();
        do_reset();
        push_all(mk_data(1), mk_mask(1));
        repeat (3) @(negedge ctl_clk);
        check(fifo_empty === 1'b0, "R4 empty latency", WW'(fifo_empty), WW'(0));
        pop_check(1, "R1 R2 pair layout");
        check(fifo_empty === 1'b1, "R6 drained", WW'(fifo_empty), WW'(1));
    endtask

    task automatic t_skew();
        do_reset();
        for (int l = 0; l < L - 1; l++) begin
            drive_lane(l, mk_data(2), mk_mask(2));
            settle();
            check(fifo_empty === 1'b1, "R4 partial word hidden", WW'(fifo_empty), WW'(1));
        end
        @(negedge ctl_clk);
        rd_en = 1'b1;
        @(negedge ctl_clk);
        rd_en = 1'b0;
        check(rd_valid === 1'b0, "R4 no pop of partial word", WW'(rd_valid), WW'(0));
        drive_lane(L - 1, mk_data(2), mk_mask(2));
        repeat (3) @(negedge ctl_clk);
        check(fifo_empty === 1'b0, "R4 all lanes present", WW'(fifo_empty), WW'(0));
        pop_check(2, "R3 skewed lanes");
    endtask

    task automatic t_b2b();
        do_reset();
        for (int k = 0; k < 3; k++) push_all(mk_data(10 + k), mk_mask(10 + k));
        settle();
        rd_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge ctl_clk);
            check(rd_valid === 1'b1, "R5 back-to-back valid", WW'(rd_valid), WW'(1));
            check(rd_data === mk_data(10 + k), "R6 order", rd_data, mk_data(10 + k));
        end
        rd_en = 1'b0;
        @(negedge ctl_clk);
        check(rd_valid === 1'b0, "R5 valid ends", WW'(rd_valid), WW'(0));
        check(fifo_empty === 1'b1, "R6 empty after burst", WW'(fifo_empty), WW'(1));
    endtask

    task automatic t_empty_read();
        do_reset();
        rd_en = 1'b1;
        repeat (2) begin
            @(negedge ctl_clk);
            check(rd_valid === 1'b0, "R7 read while empty", WW'(rd_valid), WW'(0));
        end
        rd_en = 1'b0;
        push_all(mk_data(20), mk_mask(20));
        settle();
        pop_check(20, "R7 next word after empty read");
    endtask

    task automatic t_overflow();
        do_reset();
        for (int k = 0; k < DEPTH; k++) push_all(mk_data(30 + k), mk_mask(30 + k));
        settle();
        check(overflow === 1'b0, "R8 full without overflow", WW'(overflow), WW'(0));
        push_all(mk_data(99), mk_mask(99));
        settle();
        check(overflow === 1'b1, "R8 overflow raised", WW'(overflow), WW'(1));
        for (int k = 0; k < DEPTH; k++) pop_check(30 + k, "R8 stored words intact");
        check(fifo_empty === 1'b1, "R8 dropped word absent", WW'(fifo_empty), WW'(1));
        check(overflow === 1'b1, "R8 overflow sticky", WW'(overflow), WW'(1));
        ctl_rst_n = 1'b0;
        @(negedge ctl_clk);
        check(overflow === 1'b0, "R9 reset clears overflow", WW'(overflow), WW'(0));
        check(fifo_empty === 1'b1, "R9 reset empties", WW'(fifo_empty), WW'(1));
        ctl_rst_n = 1'b1;
        @(negedge ctl_clk);
    endtask

    initial begin
        #1;
        t_reset();
        t_basic();
        t_skew();
        t_b2b();
        t_empty_read();
        t_overflow();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule